// File: doc/BRIEF.md
# Round-and-Saturate Post-Processor

This block takes a wide two's-complement accumulator word and turns it into a narrower signed result. It first rounds half-up at a chosen low bit position. It then keeps the field that runs from that position up to a chosen high bit position. If the rounded value does not fit in that field, the block clamps it to a limit and raises an overflow flag. A single clock stage registers the result.

Both positions and the clamping style are parameters, so they cannot change at run time. In asymmetric style, the negative limit is the most negative code of the field. In symmetric style, the negative limit is one code above that, so the positive and negative limits have equal magnitude. The least significant bit of the kept field sits at the rounding position, so the symmetric minimum has its lowest 1 at that position.

The block has no state machine. A state register would only duplicate the valid bit. The block is one combinational path, rounder then saturator, with a single output register.

Top module: `rs_round_sat`

## Requirements
- R1: With q = floor((x + 2^(RND_POS-1)) / 2^RND_POS), where x is the signed input, the output is q whenever q lies inside the mode's limits.
- R2: If q is greater than 2^(n-1)-1, where n = SAT_POS-RND_POS+1, the output is 2^(n-1)-1 (a 0 followed by n-1 ones) and the overflow flag is 1.
- R3: If q is below the negative limit, the output is that limit and the overflow flag is 1. In asymmetric mode the limit is -2^(n-1) (a 1 followed by zeros). In symmetric mode it is -2^(n-1)+1 (a 1 at the MSB and a 1 at the LSB).
- R4: In symmetric mode, a q of exactly -2^(n-1) is clamped to -2^(n-1)+1 with the overflow flag set. In asymmetric mode that same q passes through unchanged with the flag clear.
- R5: Overflow is judged on the rounded value. An input whose rounding increment carries it past the maximum is clamped to the maximum and flagged.
- R6: The overflow flag is 0 for every result that passes through unclamped.
- R7: The result appears one clock after the input is presented. out_valid is in_valid delayed by one clock, and out_ovf can be 1 only while out_valid is 1.
- R8: While in_valid is 0, out_data keeps its last value.
- R9: A synchronous active-high reset clears out_valid, out_ovf and out_data to 0. Reset takes priority over in_valid.
- R10: out_data is SAT_POS-RND_POS+1 bits wide and holds rounded bits [SAT_POS:RND_POS]. For a 44-bit input, the rounding position must lie in 6..21 and the saturation position in 28..43. Any other choice stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | IN_W | Signed accumulator word |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | SAT_POS-RND_POS+1 | Signed rounded and saturated field |
| out_ovf | output | 1 | Result was clamped |

## Verification
A 12-bit configuration is swept over every input code in both clamping styles. This covers exact half-way points, where truncation instead of half-up rounding would shift results down by one. It also covers the single most negative field code, where a symmetric design that forgot the extra clamp would emit the forbidden value. A 44-bit instance is driven with values placed one step either side of the rounding carry into overflow, where a design that tested overflow before rounding would wrap to the negative limit. Idle and reset cycles are interleaved to catch outputs that change without a valid input, or a flag that sticks after a clamp.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic {
        SAT_ASYM = 1'b0,
        SAT_SYM  = 1'b1
    } sat_mode_e;
endpackage

// File: rtl/rs_round.sv
// Round-half-up stage: adds half an LSB of the kept field, then drops the low bits.
module rs_round #(
    parameter int IN_W    = 44,
    parameter int RND_POS = 6,
    parameter int RW      = IN_W + 1 - RND_POS
) (
    input  logic [IN_W-1:0] din,
    output logic [RW-1:0]   dout
);
    localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (RND_POS - 1);

    logic [IN_W:0] ext;
    logic [IN_W:0] sum;

    always_comb begin
        ext  = {din[IN_W-1], din};   // one guard bit absorbs the rounding carry
        sum  = ext + HALF;
        dout = sum[IN_W:RND_POS];
    end
endmodule

// File: rtl/rs_sat.sv
// Range check and clamp of the rounded value to an OUT_W-bit signed field.
module rs_sat
    import rs_pkg::*;
#(
    parameter int        RW    = 39,
    parameter int        OUT_W = 36,
    parameter sat_mode_e MODE  = SAT_SYM
) (
    input  logic [RW-1:0]    rnd,
    input  logic             neg,
    output logic [OUT_W-1:0] q,
    output logic             ovf
);
    localparam int             UP_W     = RW - OUT_W + 1;
    localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] MAX_V    = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_V    = (MODE == SAT_SYM) ? (MOST_NEG | OUT_W'(1)) : MOST_NEG;

    logic [UP_W-1:0] upper;
    logic            fits;
    logic            edge_hit;

    assign upper = rnd[RW-1:OUT_W-1];
    assign fits  = (&upper) | ~(|upper);

    generate
        if (MODE == SAT_SYM) begin : g_sym
            assign edge_hit = fits && (rnd[OUT_W-1:0] == MOST_NEG);
        end else begin : g_asym
            assign edge_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        ovf = !fits || edge_hit;
        if (!fits) begin
            q = neg ? MIN_V : MAX_V;
        end else if (edge_hit) begin
            q = MIN_V;
        end else begin
            q = rnd[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/rs_round_sat.sv
module rs_round_sat
    import rs_pkg::*;
#(
    parameter int        IN_W    = 44,
    parameter int        RND_POS = 6,
    parameter int        SAT_POS = 41,
    parameter sat_mode_e MODE    = SAT_SYM
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [IN_W-1:0]            in_data,
    output logic                       out_valid,
    output logic [SAT_POS-RND_POS:0]   out_data,
    output logic                       out_ovf
);
    localparam int OUT_W = SAT_POS - RND_POS + 1;
    localparam int RW    = IN_W + 1 - RND_POS;

    generate
        if (RND_POS < 1 || SAT_POS <= RND_POS || SAT_POS >= IN_W) begin : g_bad_pos
            $error("rs_round_sat: invalid rounding/saturation positions");
        end
        if (IN_W == 44 && (RND_POS < 6 || RND_POS > 21 || SAT_POS < 28 || SAT_POS > 43)) begin : g_bad_win
            $error("rs_round_sat: position outside its 44-bit window");
        end
    endgenerate

    logic [RW-1:0]    rnd_val;
    logic [OUT_W-1:0] sat_val;
    logic             sat_ovf;

    rs_round #(.IN_W(IN_W), .RND_POS(RND_POS), .RW(RW)) u_round (
        .din  (in_data),
        .dout (rnd_val)
    );

    rs_sat #(.RW(RW), .OUT_W(OUT_W), .MODE(MODE)) u_sat (
        .rnd (rnd_val),
        .neg (in_data[IN_W-1]),
        .q   (sat_val),
        .ovf (sat_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ovf   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_ovf   <= in_valid && sat_ovf;
            if (in_valid) begin
                out_data <= sat_val;
            end
        end
    end
endmodule

// File: rtl/rs_round_sat_chk.sv
module rs_round_sat_chk
    import rs_pkg::*;
#(
    parameter int        OUT_W = 36,
    parameter sat_mode_e MODE  = SAT_SYM
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             out_ovf
);
    localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] MAX_V    = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_V    = (MODE == SAT_SYM) ? (MOST_NEG | OUT_W'(1)) : MOST_NEG;

    assert_valid_delay_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_ovf_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> out_valid);

    assert_ovf_at_limit_R3: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> (out_data == MAX_V || out_data == MIN_V));

    assert_sym_no_most_neg_R4: assert property (@(posedge clk) disable iff (rst)
        (MODE == SAT_SYM && out_valid) |-> (out_data != MOST_NEG));

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(out_data));

    assert_reset_clears_R9: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_ovf && out_data == '0));
endmodule

bind rs_round_sat rs_round_sat_chk #(.OUT_W(OUT_W), .MODE(MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ovf   (out_ovf)
);

// File: tb/rs_round_sat_test.sv
`timescale 1ns/1ps
module rs_round_sat_test;
    import rs_pkg::*;

    localparam int SW = 12, SR = 3, SS = 8, SN = SS - SR + 1;
    localparam int WR = 6, WS = 41, WN = WS - WR + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [SW-1:0] xs = '0;
    logic [43:0]   xw = '0;
    logic vw = 1'b0;

    logic s_v, s_o, a_v, a_o, w_v, w_o;
    logic [SN-1:0] s_d, a_d;
    logic [WN-1:0] w_d;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rs_round_sat #(.IN_W(SW), .RND_POS(SR), .SAT_POS(SS), .MODE(SAT_SYM)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(xs),
        .out_valid(s_v), .out_data(s_d), .out_ovf(s_o));

    rs_round_sat #(.IN_W(SW), .RND_POS(SR), .SAT_POS(SS), .MODE(SAT_ASYM)) uut_asym (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(xs),
        .out_valid(a_v), .out_data(a_d), .out_ovf(a_o));

    rs_round_sat uut_wide (
        .clk(clk), .rst(rst), .in_valid(vw), .in_data(xw),
        .out_valid(w_v), .out_data(w_d), .out_ovf(w_o));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void model(longint x, int r, int s, bit sym,
                                  output longint q, output bit ov, output string tag);
        longint one = 1;
        longint rv = (x + (one << (r - 1))) >>> r;
        int     n  = s - r + 1;
        longint mx = (one << (n - 1)) - 1;
        longint mn = -(one << (n - 1)) + (sym ? 1 : 0);
        q = rv; ov = 1'b0; tag = "R1/R6";
        if (rv > mx) begin q = mx; ov = 1'b1; tag = "R2/R5"; end
        else if (rv < mn) begin
            q = mn; ov = 1'b1;
            tag = (rv == mn - 1 && sym) ? "R4" : "R3";
        end else if (!sym && rv == mn) tag = "R4";
    endfunction

    initial begin : watchdog
        #900000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin : stim
        longint q; bit ov; string tag;
        longint one = 1;
        logic [SN-1:0] last_s, last_a;
        longint wv[8];

        // R9: reset wins over in_valid
        @(negedge clk);
        in_valid = 1'b1; xs = 12'h7FF; vw = 1'b1; xw = 44'h5926AC01342;
        @(negedge clk);
        @(negedge clk);
        chk("R9 valid", {63'd0, s_v}, 64'd0);
        chk("R9 ovf", {63'd0, s_o}, 64'd0);
        chk("R9 data", {58'd0, s_d}, 64'd0);
        chk("R9 wide", {27'd0, w_v, w_o, w_d}, 64'd0);
        in_valid = 1'b0; vw = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R7 idle after reset", {62'd0, s_v, a_v}, 64'd0);

        // R10: field width
        chk("R10 width", 64'($bits(w_d)), 64'd36);
        chk("R10 small width", 64'($bits(s_d)), 64'(SN));

        last_s = '0; last_a = '0;
        for (int i = 0; i < (1 << SW); i++) begin
            xs = SW'(i); in_valid = 1'b1;
            @(negedge clk);
            model(longint'($signed(xs)), SR, SS, 1'b1, q, ov, tag);
            chk({tag, " sym data"}, {58'd0, s_d}, {58'd0, q[SN-1:0]});
            chk({tag, " sym ovf"}, {63'd0, s_o}, {63'd0, ov});
            chk("R7 sym valid", {63'd0, s_v}, 64'd1);
            last_s = q[SN-1:0];
            model(longint'($signed(xs)), SR, SS, 1'b0, q, ov, tag);
            chk({tag, " asym data"}, {58'd0, a_d}, {58'd0, q[SN-1:0]});
            chk({tag, " asym ovf"}, {63'd0, a_o}, {63'd0, ov});
            last_a = q[SN-1:0];
            if (i % 512 == 511) begin
                in_valid = 1'b0; xs = ~xs;
                @(negedge clk);
                chk("R7 valid low", {62'd0, s_v, a_v}, 64'd0);
                chk("R7 ovf low", {62'd0, s_o, a_o}, 64'd0);
                chk("R8 hold sym", {58'd0, s_d}, {58'd0, last_s});
                chk("R8 hold asym", {58'd0, a_d}, {58'd0, last_a});
            end
        end
        in_valid = 1'b0;

        wv[0] = ((one << 35) - 1) * 64 + 31;      // just below the carry
        wv[1] = ((one << 35) - 1) * 64 + 32;      // carry pushes past max (R5)
        wv[2] = -(one << 41);                     // exact most negative (R4)
        wv[3] = longint'($signed(44'h5926AC01342));
        wv[4] = longint'($signed(44'hADA38D22100));
        wv[5] = 12345;
        wv[6] = -(one << 41) - 33;                // below min (R3)
        wv[7] = -96;                              // exact half, negative (R1)
        for (int k = 0; k < 8; k++) begin
            xw = wv[k][43:0]; vw = 1'b1;
            @(negedge clk);
            model(wv[k], WR, WS, 1'b1, q, ov, tag);
            chk({tag, " wide data"}, {28'd0, w_d}, {28'd0, q[WN-1:0]});
            chk({tag, " wide ovf"}, {63'd0, w_o}, {63'd0, ov});
            chk("R7 wide valid", {63'd0, w_v}, 64'd1);
        end
        vw = 1'b0;
        @(negedge clk);
        chk("R7 wide drop", {62'd0, w_v, w_o}, 64'd0);

        // R9 mid-run reset
        in_valid = 1'b1; xs = 12'h400; rst = 1'b1;
        @(negedge clk);
        chk("R9 midrun", {56'd0, s_v, s_o, s_d}, 64'd0);
        rst = 1'b0; in_valid = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule